// File: doc/BRIEF.md
# Serial LED Chain Driver

The block streams up to 24 output bits into a cascade of external 8-bit shift registers, usually to light status LEDs. It produces a serial data line, a shift clock and a store strobe that moves the shifted pattern into the output latches of the registers. Software owns the pattern through a shadow data register. An update is started either by a self-clearing request bit or by a periodic automatic tick.

Some low-order chain bits can be handed to hardware status sources: two bits from a DSL modem and two 3-bit slots from two PHY blocks. For each chain bit that a source owns, the status input replaces the shadow bit. While any bit is owned this way, the automatic tick refreshes the chain at one of four selectable rates. The register port is plain and has no back-pressure: every write is accepted in the cycle it is presented, and reads return data combinationally. The serial stream has no handshake. The external cascade takes bits on the sampling edge of the shift clock and transfers them to its outputs when the store strobe is high.

Top module: `led_chain_drv`

## Requirements
- R1: After reset, chain_sclk, chain_sdata and chain_store are low, and the configuration (0x0), update (0x4) and shadow (0x8) registers all read 0.
- R2: Writing 1 to bit 0 of the update register (0x4) shifts the shadow register (0x8) out as one frame. Each bit occupies CLK_DIV system clock cycles.
- R3: The frame length is 8 times the position of the highest set bit among the group enables in configuration bits [2:0]. For example, 3'b001 gives 8 bits, 3'b011 gives 16 bits, and 3'b100 or 3'b101 give 24 bits.
- R4: When no group is enabled, update requests are discarded. No shift or store activity occurs, and update bit 0 reads 0.
- R5: Bits leave most significant first, starting from bit length-1. The store strobe is high for exactly CLK_DIV cycles, starting right after the last bit. The shift clock stays at its idle level during the strobe.
- R6: Configuration bit 3 selects the edge. When it is 0, the shift clock idles low, data changes with its rising edge and is sampled on the falling edge. When it is 1, the shift clock idles high, data changes with its falling edge and is sampled on the rising edge.
- R7: Configuration bits [7:6] give bit k of dsl_status ownership of chain bit k. A value n in [9:8] hands chain bits 2 to 1+n to phy1_status[n-1:0]. A value n in [11:10] hands chain bits 5 to 4+n to phy2_status[n-1:0]. Owned bits take the status input in place of the shadow bit.
- R8: While any chain bit is owned, a frame starts every REF_HZ/f cycles. The rate f is selected by configuration bits [5:4]: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 10. With no owned bit, no automatic frame occurs.
- R9: Update bit 0 reads 1 from the request until the frame that serves it completes, then clears itself. A request written during a frame is held and served by the next frame.
- R10: Frame content is captured when the frame starts. A shadow write made during a frame affects only later frames.
- R11: The configuration register reads back its 12 bits and the shadow register its 24 bits. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dsl_status | input | 2 | DSL modem status bits |
| phy1_status | input | 3 | First PHY status bits |
| phy2_status | input | 3 | Second PHY status bits |
| chain_sclk | output | 1 | Shift clock to the cascade |
| chain_sdata | output | 1 | Serial data to the cascade |
| chain_store | output | 1 | Store strobe to the cascade |

## Verification
The bench works on the frame length. It enables non-contiguous groups and no groups at all. A design that counted enabled groups instead of taking the highest one would shift 16 bits for 3'b101. A design that ignored the empty case would emit empty frames or leave the request bit stuck high. The bench mixes hardware-owned and shadow bits in the same byte and uses partial PHY slot widths. A wrong ownership decode therefore appears as a wrong bit in the frame, and a swapped shift order appears as a mirrored pattern. The bench also issues a second request and a shadow write while a 24-bit frame is in flight. A design that dropped the queued request, or sampled the shadow register late, would lose a frame or shift the wrong pattern. The bench measures the store strobe width, the interval between automatic frames at two rates, and the idle clock level in both edge modes.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;
  localparam int GROUP_W  = 8;
  localparam int GROUPS   = 3;
  localparam int CHAIN_W  = GROUP_W * GROUPS;
  localparam int LEN_W    = $clog2(CHAIN_W + 1);
  localparam int CFG_W    = 12;
  localparam int REG_W    = 32;

  localparam logic [3:0] ADDR_CFG  = 4'h0;
  localparam logic [3:0] ADDR_UPD  = 4'h4;
  localparam logic [3:0] ADDR_DATA = 4'h8;

  typedef struct packed {
    logic [1:0] phy2_own;
    logic [1:0] phy1_own;
    logic [1:0] dsl_own;
    logic [1:0] rate;
    logic       fall_edge;
    logic [2:0] grp_en;
  } cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_STORE = 2'd2
  } seq_t;

  function automatic int unsigned rate_hz(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/led_chain_tick.sv
module led_chain_tick #(
  parameter int unsigned REF_HZ = 250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  import led_chain_pkg::*;

  localparam int unsigned P_MAX = REF_HZ / 2;
  localparam int CNT_W = $clog2(P_MAX + 1);

  logic [CNT_W-1:0] lim_tbl [4];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tbl[g] = CNT_W'(REF_HZ / rate_hz(2'(g)) - 1);
  end

  assign limit = lim_tbl[rate];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (cnt >= limit) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8: ticks are isolated pulses
  a_r8_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8: no tick while nothing is owned
  a_r8_tick_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(rst_n)) |-> $past(run));
endmodule

// File: rtl/led_chain_merge.sv
module led_chain_merge
  import led_chain_pkg::*;
(
  input  logic [1:0]         dsl_own,
  input  logic [1:0]         phy1_own,
  input  logic [1:0]         phy2_own,
  input  logic [CHAIN_W-1:0] shadow,
  input  logic [1:0]         dsl_st,
  input  logic [2:0]         phy1_st,
  input  logic [2:0]         phy2_st,
  output logic [CHAIN_W-1:0] frame,
  output logic               own_any
);
  localparam int HW_W   = 8;
  localparam int P1_LSB = 2;
  localparam int P2_LSB = 5;

  logic [CHAIN_W-1:0] own;
  logic [CHAIN_W-1:0] hw;

  assign hw = {{(CHAIN_W-HW_W){1'b0}}, phy2_st, phy1_st, dsl_st};

  for (genvar k = 0; k < 2; k++) begin : g_dsl
    assign own[k] = dsl_own[k];
  end

  for (genvar j = 0; j < 3; j++) begin : g_phy
    assign own[P1_LSB+j] = (phy1_own > 2'(j));
    assign own[P2_LSB+j] = (phy2_own > 2'(j));
  end

  assign own[CHAIN_W-1:HW_W] = '0;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_mux
    assign frame[i] = own[i] ? hw[i] : shadow[i];
  end

  assign own_any = |own;
endmodule

// File: rtl/led_chain_shift.sv
module led_chain_shift
  import led_chain_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [CHAIN_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               fall_edge,
  output logic               sclk,
  output logic               sdata,
  output logic               latch,
  output logic               start,
  output logic               done,
  output logic               busy
);
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] HALF     = DIV_W'(CLK_DIV / 2);

  seq_t               state;
  logic [DIV_W-1:0]   div;
  logic [LEN_W-1:0]   left;
  logic [CHAIN_W-1:0] shreg;
  logic               edge_q;

  assign start = (state == SEQ_IDLE) && go;
  assign done  = (state == SEQ_STORE) && (div == DIV_LAST);
  assign busy  = (state != SEQ_IDLE);
  assign sclk  = edge_q ^ ((state == SEQ_SHIFT) && (div < HALF));
  assign sdata = (state == SEQ_SHIFT) && shreg[CHAIN_W-1];
  assign latch = (state == SEQ_STORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      div    <= '0;
      left   <= '0;
      shreg  <= '0;
      edge_q <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          edge_q <= fall_edge;
          div    <= '0;
          if (go) begin
            shreg <= frame << (LEN_W'(CHAIN_W) - len);
            left  <= len - 1'b1;
            state <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (div == DIV_LAST) begin
            div <= '0;
            if (left == '0) begin
              state <= SEQ_STORE;
            end else begin
              left  <= left - 1'b1;
              shreg <= shreg << 1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        SEQ_STORE: begin
          if (div == DIV_LAST) begin
            div   <= '0;
            state <= SEQ_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R3: a frame never starts with zero length
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (len != '0));

  // R5: the store strobe follows shifting directly
  a_r5_store_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $past(state) == SEQ_SHIFT);

  // R5: the strobe ends only after its full period
  a_r5_store_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch) |-> $past(div) == DIV_LAST);

  // R6: edge mode is frozen for the whole frame
  a_r6_edge_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(edge_q));
endmodule

// File: rtl/led_chain_regs.sv
module led_chain_regs
  import led_chain_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [3:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output cfg_t               cfg,
  output logic [CHAIN_W-1:0] shadow,
  output logic               req,
  input  logic               start,
  input  logic               done,
  input  logic               busy,
  input  logic               tick,
  input  logic               len_zero
);
  logic sw_pend;
  logic sw_active;
  logic auto_pend;
  logic unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:CHAIN_W];
  assign req = sw_pend | auto_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      shadow    <= '0;
      sw_pend   <= 1'b0;
      sw_active <= 1'b0;
      auto_pend <= 1'b0;
    end else begin
      if (wr && addr == ADDR_CFG)  cfg    <= cfg_t'(wdata[CFG_W-1:0]);
      if (wr && addr == ADDR_DATA) shadow <= wdata[CHAIN_W-1:0];
      if (done) sw_active <= 1'b0;
      if (start) begin
        sw_active <= sw_pend;
        sw_pend   <= 1'b0;
        auto_pend <= 1'b0;
      end else if (!busy && len_zero) begin
        sw_pend   <= 1'b0;
        auto_pend <= 1'b0;
      end
      if (wr && addr == ADDR_UPD && wdata[0]) sw_pend <= 1'b1;
      if (tick) auto_pend <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CFG:  rdata = {{(REG_W-CFG_W){1'b0}}, cfg};
      ADDR_UPD:  rdata = {{(REG_W-1){1'b0}}, sw_pend | sw_active};
      ADDR_DATA: rdata = {{(REG_W-CHAIN_W){1'b0}}, shadow};
      default:   rdata = '0;
    endcase
  end

  // R9: a served request clears only when its frame completes
  a_r9_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_active) |-> $past(done));

  // R9: an active request belongs to a running frame
  a_r9_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sw_active |-> busy);
endmodule

// File: rtl/led_chain_drv.sv
module led_chain_drv #(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned REF_HZ  = 250_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  dsl_status,
  input  logic [2:0]  phy1_status,
  input  logic [2:0]  phy2_status,
  output logic        chain_sclk,
  output logic        chain_sdata,
  output logic        chain_store
);
  import led_chain_pkg::*;

  cfg_t               cfg;
  logic [CHAIN_W-1:0] shadow;
  logic [CHAIN_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               own_any, req, tick, start, done, busy, len_zero, go;

  always_comb begin
    len = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (cfg.grp_en[g]) len = LEN_W'((g + 1) * GROUP_W);
    end
  end

  assign len_zero = (len == '0);
  assign go       = req && !len_zero;

  led_chain_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .cfg      (cfg),
    .shadow   (shadow),
    .req      (req),
    .start    (start),
    .done     (done),
    .busy     (busy),
    .tick     (tick),
    .len_zero (len_zero)
  );

  led_chain_merge u_merge (
    .dsl_own  (cfg.dsl_own),
    .phy1_own (cfg.phy1_own),
    .phy2_own (cfg.phy2_own),
    .shadow   (shadow),
    .dsl_st   (dsl_status),
    .phy1_st  (phy1_status),
    .phy2_st  (phy2_status),
    .frame    (frame),
    .own_any  (own_any)
  );

  led_chain_tick #(.REF_HZ(REF_HZ)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (own_any),
    .rate  (cfg.rate),
    .tick  (tick)
  );

  led_chain_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .frame     (frame),
    .len       (len),
    .fall_edge (cfg.fall_edge),
    .sclk      (chain_sclk),
    .sdata     (chain_sdata),
    .latch     (chain_store),
    .start     (start),
    .done      (done),
    .busy      (busy)
  );

  // R4: nothing leaves the block while no group is enabled
  a_r4_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (len_zero && !busy) |=> !chain_store);
endmodule

// File: tb/led_chain_drv_bench.sv
`timescale 1ns/1ps
module led_chain_drv_bench;
  localparam int CLK_DIV = 4;
  localparam int REF_HZ  = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dsl_status = '0;
  logic [2:0]  phy1_status = '0;
  logic [2:0]  phy2_status = '0;
  logic        chain_sclk, chain_sdata, chain_store;

  led_chain_drv #(.CLK_DIV(CLK_DIV), .REF_HZ(REF_HZ)) u_led_chain_drv (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsl_status(dsl_status),
    .phy1_status(phy1_status), .phy2_status(phy2_status),
    .chain_sclk(chain_sclk), .chain_sdata(chain_sdata), .chain_store(chain_store)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic fall_mode = 1'b0;

  int          exp_len[$];
  logic [23:0] exp_val[$];
  string       exp_tag[$];

  int frames_seen = 0;
  int cyc = 0;
  int last_frame_cyc = 0;
  int intv = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic push(input int n, input logic [23:0] v, input string tag);
    logic [23:0] m;
    m = (n >= 24) ? 24'hFFFFFF : ((24'd1 << n) - 24'd1);
    exp_len.push_back(n);
    exp_val.push_back(v & m);
    exp_tag.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(input logic [2:0] grp, input logic fe, input logic [1:0] rate,
                         input logic [1:0] dsl_o, input logic [1:0] p1o, input logic [1:0] p2o);
    wr(4'h0, {20'd0, p2o, p1o, dsl_o, rate, fe, grp});
    fall_mode = fe;
    repeat (12) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    while (frames_seen < n) @(negedge clk);
  endtask

  function automatic logic [23:0] model(input logic [23:0] sh, input logic [1:0] dsl_o,
      input logic [1:0] p1o, input logic [1:0] p2o, input logic [1:0] ds,
      input logic [2:0] p1s, input logic [2:0] p2s);
    logic [23:0] r;
    r = sh;
    if (dsl_o[0]) r[0] = ds[0];
    if (dsl_o[1]) r[1] = ds[1];
    for (int j = 0; j < int'(p1o); j++) r[2+j] = p1s[j];
    for (int j = 0; j < int'(p2o); j++) r[5+j] = p2s[j];
    return r;
  endfunction

  // monitor / scoreboard
  logic        prev_sclk = 1'b0, prev_store = 1'b0;
  logic [23:0] acc = '0;
  int          nbits = 0, quiet = 0, lat_w = 0;

  always @(negedge clk) begin
    logic raw, prev_raw;
    cyc++;
    if (!rst_n) begin
      prev_sclk = chain_sclk; prev_store = chain_store; acc = '0; nbits = 0;
    end else begin
      raw = chain_sclk ^ fall_mode;
      prev_raw = prev_sclk ^ fall_mode;
      if (chain_sclk != prev_sclk) quiet = 0; else quiet++;
      if (quiet > 2 * CLK_DIV && !chain_store) begin nbits = 0; acc = '0; end
      if (prev_raw && !raw) begin acc = {acc[22:0], chain_sdata}; nbits++; end
      if (chain_store && !prev_store) begin
        frames_seen++;
        intv = cyc - last_frame_cyc;
        last_frame_cyc = cyc;
        if (exp_len.size() == 0) begin
          chk(0, "R2 unexpected frame", acc, 0);
        end else begin
          int el; logic [23:0] ev; string et;
          el = exp_len.pop_front(); ev = exp_val.pop_front(); et = exp_tag.pop_front();
          chk(nbits == el, {et, " frame length"}, nbits, el);
          chk(acc == ev, {et, " frame bits msb-first R5"}, acc, ev);
        end
        nbits = 0; acc = '0; lat_w = 0;
      end
      if (chain_store) begin
        lat_w++;
        chk(chain_sclk == fall_mode, "R5 shift clock idle during store", chain_sclk, fall_mode);
      end
      if (!chain_store && prev_store) chk(lat_w == CLK_DIV, "R5 store width", lat_w, CLK_DIV);
      prev_sclk = chain_sclk; prev_store = chain_store;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int f0;
    logic [23:0] ev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(chain_sclk == 0 && chain_sdata == 0 && chain_store == 0, "R1 outputs after reset",
        {chain_sclk, chain_sdata, chain_store}, 0);
    rd(4'h0, d); chk(d == 0, "R1 cfg reset", d, 0);
    rd(4'h4, d); chk(d == 0, "R1 update reset", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 shadow reset", d, 0);

    // R2: one group, software update
    set_cfg(3'b001, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    wr(4'h8, 32'h0000_00A5);
    push(8, 24'h0000A5, "R2");
    wr(4'h4, 32'h1);
    wait_frames(1);

    // R3: lengths from highest group
    set_cfg(3'b011, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    wr(4'h8, 32'h0000_C35A);
    push(16, 24'h00C35A, "R3 grp011");
    wr(4'h4, 32'h1);
    wait_frames(2);
    set_cfg(3'b100, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    wr(4'h8, 32'h009A_BCDE);
    push(24, 24'h9ABCDE, "R3 grp100");
    wr(4'h4, 32'h1);
    wait_frames(3);
    set_cfg(3'b101, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    wr(4'h8, 32'h0081_0203);
    push(24, 24'h810203, "R3 grp101");
    wr(4'h4, 32'h1);
    wait_frames(4);
    repeat (10) @(negedge clk);

    // R4: no group enabled
    set_cfg(3'b000, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    f0 = frames_seen;
    wr(4'h4, 32'h1);
    repeat (100) @(negedge clk);
    chk(frames_seen == f0, "R4 no frame without groups", frames_seen, f0);
    rd(4'h4, d); chk(d == 0, "R4 request discarded", d, 0);

    // R6: falling edge mode
    set_cfg(3'b001, 1, 2'd0, 2'b00, 2'd0, 2'd0);
    chk(chain_sclk == 1, "R6 idle high in falling mode", chain_sclk, 1);
    wr(4'h8, 32'h0000_003C);
    push(8, 24'h00003C, "R6 falling");
    wr(4'h4, 32'h1);
    wait_frames(5);
    repeat (10) @(negedge clk);
    set_cfg(3'b001, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    chk(chain_sclk == 0, "R6 idle low in rising mode", chain_sclk, 0);

    // R7 + R8: ownership with automatic refresh at rate code 3
    dsl_status = 2'b10; phy1_status = 3'b101; phy2_status = 3'b010;
    wr(4'h8, 32'h0000_F0F0);
    ev = model(24'h00F0F0, 2'b01, 2'd2, 2'd3, 2'b10, 3'b101, 3'b010);
    for (int i = 0; i < 3; i++) push(16, ev, "R7 owned bits");
    set_cfg(3'b011, 0, 2'd3, 2'b01, 2'd2, 2'd3);
    wait_frames(8);
    chk(intv == REF_HZ / 10, "R8 interval rate 3", intv, REF_HZ / 10);
    wr(4'h0, 32'h0000_0003);
    repeat (12) @(negedge clk);

    // R8: rate code 1, only DSL bit 1 owned
    dsl_status = 2'b11;
    ev = model(24'h00F0F0, 2'b10, 2'd0, 2'd0, 2'b11, 3'b000, 3'b000);
    for (int i = 0; i < 2; i++) push(8, ev, "R8 dsl only");
    set_cfg(3'b001, 0, 2'd1, 2'b10, 2'd0, 2'd0);
    wait_frames(10);
    chk(intv == REF_HZ / 4, "R8 interval rate 1", intv, REF_HZ / 4);
    wr(4'h0, 32'h0000_0011);
    f0 = frames_seen;
    repeat (1200) @(negedge clk);
    chk(frames_seen == f0, "R8 no auto frame without owners", frames_seen, f0);

    // R9 + R10: request queued during a frame, shadow captured at start
    set_cfg(3'b111, 0, 2'd0, 2'b00, 2'd0, 2'd0);
    wr(4'h8, 32'h0012_3456);
    push(24, 24'h123456, "R10 first frame");
    push(24, 24'hFEDCBA, "R9 queued frame");
    wr(4'h4, 32'h1);
    repeat (5) @(negedge clk);
    rd(4'h4, d); chk(d == 1, "R9 busy while shifting", d, 1);
    wr(4'h8, 32'h00FE_DCBA);
    wr(4'h4, 32'h1);
    wait_frames(f0 + 1);
    rd(4'h4, d); chk(d == 1, "R9 held request pending", d, 1);
    wait_frames(f0 + 2);
    repeat (10) @(negedge clk);
    rd(4'h4, d); chk(d == 0, "R9 self-clear", d, 0);

    // R11: readback masking
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk(d == 32'h00FF_FFFF, "R11 shadow readback", d, 32'h00FF_FFFF);
    wr(4'h0, 32'hFFFF_F000);
    rd(4'h0, d); chk(d == 32'h0, "R11 cfg upper bits", d, 0);
    wr(4'h0, 32'h0000_0001);
    rd(4'h0, d); chk(d == 32'h1, "R11 cfg readback", d, 1);
    rd(4'hC, d); chk(d == 0, "R11 unmapped reads zero", d, 0);

    repeat (20) @(negedge clk);
    chk(exp_len.size() == 0, "R2 all expected frames seen", exp_len.size(), 0);
    finish_run();
  end
endmodule